// File: doc/BRIEF.md
# Power-Fail Access and Backup Supervisor

This block sequences access and backup power for a battery-backed memory with a time-of-day counter. Two comparator flags report whether the main supply is above the write-protect threshold and whether it is above the battery-switch threshold. A static strap says which of the two thresholds is lower. The block turns these flags and the host's select, read and write requests into a gated memory select, a gated write strobe and a bus-drive enable. It also produces the backup-supply select and a one-time battery-arm latch.

Access is removed as soon as the synchronized write-protect flag drops. When the supply comes back, access returns only after a recovery interval of `REC_CYCLES` system clocks with the supply held good. A dip inside that interval starts the count again. A write in progress when power fails is cancelled. A write request that is still held when access returns gets no strobe until the host withdraws it. The battery stays disconnected until the supply first rises above the write-protect threshold, so backup selection is suppressed before that. After that the latch stays set until reset.

There is no data stream in this block. All pins are plain level-sensitive control and status signals, with no valid/ready handshake and no back-pressure.

Top module: `pwr_supervisor`

## Requirements
- R1: Both comparator flags pass through two flip-flops. A change driven before clock edge 1 takes effect on the outputs after edge 2.
- R2: While the synchronized write-protect flag is low, `mem_sel_o`, `mem_wr_o`, `bus_drive_o` and `access_en_o` are all 0. With the bus drive off, the data bus stays in high impedance.
- R3: After the write-protect flag rises before edge 1 and then stays high, `access_en_o` is 0 after edge `REC_CYCLES`+2 and 1 after edge `REC_CYCLES`+3.
- R4: If the write-protect flag drops during the recovery interval, the interval restarts in full once the flag is good again.
- R5: `batt_armed_o` is 0 after reset. It sets after edge 3 following the first rise of the write-protect flag and then stays 1. The battery-switch flag alone never sets it.
- R6: While `batt_armed_o` is 0, `bkup_sel_o` is 0 whatever the flags are.
- R7: With `wp_lower_strap_i`=1 (write-protect threshold lower), an armed block sets `bkup_sel_o`=1 exactly when the synchronized write-protect flag is 0.
- R8: With `wp_lower_strap_i`=0 (switch threshold lower), an armed block sets `bkup_sel_o`=1 exactly when the synchronized battery-switch flag is 0. The write-protect flag has no effect on it.
- R9: `mem_wr_o` = `host_sel_i` & `host_wr_i` while access is enabled. The exception: a write request that was held while access was off, and is still held, gives `mem_wr_o`=0 until the host drops `host_wr_i` or `host_sel_i` for at least one clock.
- R10: `bus_drive_o` is 1 only when `host_sel_i`=1, `host_rd_i`=1, `host_wr_i`=0 and access is enabled. `mem_sel_o` = `host_sel_i` & access enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_above_i | input | 1 | Asynchronous flag: supply above write-protect threshold |
| sw_above_i | input | 1 | Asynchronous flag: supply above battery-switch threshold |
| wp_lower_strap_i | input | 1 | Static strap: 1 when the write-protect threshold is the lower one |
| host_sel_i | input | 1 | Host select request, active high |
| host_rd_i | input | 1 | Host read request, active high |
| host_wr_i | input | 1 | Host write request, active high |
| mem_sel_o | output | 1 | Gated memory select |
| mem_wr_o | output | 1 | Gated memory write strobe |
| bus_drive_o | output | 1 | Data bus output enable (0 means high impedance) |
| access_en_o | output | 1 | Access currently permitted |
| bkup_sel_o | output | 1 | Select backup battery supply |
| batt_armed_o | output | 1 | Battery connected (one-time latch) |

## Verification
The assertions check on every cycle the rules that hold in any state. Gated outputs stay off while the synchronized write-protect flag is low. Access never opens before the supply has been good for the full recovery count, which a counter beside the assertion measures. The arm latch never clears, and no backup select occurs while unarmed. A held, blocked write never gains a strobe. The bench scenarios show the exact edge on which recovery ends, the restart after a dip, the effect of the strap on the switchover point, and the fact that the switch flag cannot arm the battery.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    PH_DOWN = 2'd0,
    PH_WAIT = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[b] <= '0;
      else        chain[b] <= {chain[b][STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/pfs_recovery.sv
module pfs_recovery
  import pfs_pkg::*;
#(
  parameter int REC_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_ok,
  output logic access_en
);
  localparam int CW = $clog2(REC_CYCLES + 2);
  localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DOWN;
      cnt_q   <= '0;
    end else if (!wp_ok) begin
      phase_q <= PH_DOWN;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_DOWN: begin
          phase_q <= PH_WAIT;
          cnt_q   <= '0;
        end
        PH_WAIT: begin
          if (cnt_q == LAST) phase_q <= PH_RUN;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign access_en = (phase_q == PH_RUN) && wp_ok;

  // checker counter: consecutive good-supply cycles, saturating
  logic [CW-1:0] good_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                good_run_q <= '0;
    else if (!wp_ok)                           good_run_q <= '0;
    else if (good_run_q != CW'(REC_CYCLES + 1)) good_run_q <= good_run_q + 1'b1;
  end

  // R3 / R4: access only after a full uninterrupted recovery count
  a_r3_full_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    access_en |-> (good_run_q > CW'(REC_CYCLES)));
endmodule

// File: rtl/pfs_backup.sv
module pfs_backup (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_ok,
  input  logic sw_ok,
  input  logic wp_lower,
  output logic armed,
  output logic bkup_sel
);
  logic armed_q;
  logic below_switch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_q | wp_ok;
  end

  always_comb begin
    if (wp_lower) below_switch = !wp_ok;
    else          below_switch = !sw_ok;
  end

  assign armed    = armed_q;
  assign bkup_sel = armed_q & below_switch;

  // R5: arm latch is one-time and sticky
  a_r5_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  // R5: only the write-protect flag may set the latch
  a_r5_arm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !wp_ok) |=> !armed_q);
endmodule

// File: rtl/pfs_gate.sv
module pfs_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic access_en,
  input  logic host_sel,
  input  logic host_rd,
  input  logic host_wr,
  output logic mem_sel,
  output logic mem_wr,
  output logic bus_drive
);
  logic wr_req;
  logic wr_ok_q;

  assign wr_req = host_sel & host_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wr_ok_q <= 1'b1;
    else if (!wr_req)    wr_ok_q <= 1'b1;
    else if (!access_en) wr_ok_q <= 1'b0;
  end

  assign mem_sel   = host_sel & access_en;
  assign mem_wr    = wr_req & access_en & wr_ok_q;
  assign bus_drive = host_sel & host_rd & !host_wr & access_en;

  // R9: a held request that gave no strobe never starts one later
  a_r9_held_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !access_en) |=> (wr_req -> !mem_wr));
  // R10: bus is driven only for a pure read
  a_r10_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (host_rd && !host_wr && mem_sel));
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int REC_CYCLES  = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_above_i,
  input  logic sw_above_i,
  input  logic wp_lower_strap_i,
  input  logic host_sel_i,
  input  logic host_rd_i,
  input  logic host_wr_i,
  output logic mem_sel_o,
  output logic mem_wr_o,
  output logic bus_drive_o,
  output logic access_en_o,
  output logic bkup_sel_o,
  output logic batt_armed_o
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] flags_s;
  logic             wp_s;
  logic             sw_s;
  logic             acc;

  pfs_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({sw_above_i, wp_above_i}),
    .sync_o (flags_s)
  );
  assign wp_s = flags_s[0];
  assign sw_s = flags_s[1];

  pfs_recovery #(.REC_CYCLES(REC_CYCLES)) u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_ok    (wp_s),
    .access_en(acc)
  );

  pfs_backup u_bkup (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp_ok   (wp_s),
    .sw_ok   (sw_s),
    .wp_lower(wp_lower_strap_i),
    .armed   (batt_armed_o),
    .bkup_sel(bkup_sel_o)
  );

  pfs_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .access_en(acc),
    .host_sel (host_sel_i),
    .host_rd  (host_rd_i),
    .host_wr  (host_wr_i),
    .mem_sel  (mem_sel_o),
    .mem_wr   (mem_wr_o),
    .bus_drive(bus_drive_o)
  );

  assign access_en_o = acc;

  // R2: nothing reaches the memory while below write-protect
  a_r2_blocked_below: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_s |-> (!mem_sel_o && !mem_wr_o && !bus_drive_o));
  // R6: no backup selection before the battery is armed
  a_r6_no_bkup_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    bkup_sel_o |-> batt_armed_o);
endmodule

// File: tb/pwr_supervisor_tb.sv
module pwr_supervisor_tb;
  localparam int N = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic wp = 0, sw = 0, strap = 1;
  logic sel = 0, rd = 0, wr = 0;
  logic mem_sel, mem_wr, bus_drive, access_en, bkup_sel, armed;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  pwr_supervisor #(.REC_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wp_above_i(wp), .sw_above_i(sw), .wp_lower_strap_i(strap),
    .host_sel_i(sel), .host_rd_i(rd), .host_wr_i(wr),
    .mem_sel_o(mem_sel), .mem_wr_o(mem_wr), .bus_drive_o(bus_drive),
    .access_en_o(access_en), .bkup_sel_o(bkup_sel), .batt_armed_o(armed)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drive_at_negedge();
    @(negedge clk);
  endtask

  // full power-up from down; returns with access enabled
  task automatic power_up();
    drive_at_negedge();
    wp = 1; sw = 1;
    edges(N + 3);
  endtask

  task automatic t_reset();
    edges(1);
    check("R5 reset armed", armed, 0);
    check("R2 reset access", access_en, 0);
    check("R2 reset mem_sel", mem_sel, 0);
    rst_n = 1;
    drive_at_negedge();
    sw = 1; wp = 0; sel = 1; rd = 1;
    edges(6);
    check("R5 switch flag alone no arm", armed, 0);
    check("R6 no bkup unarmed", bkup_sel, 0);
    check("R2 bus drive below", bus_drive, 0);
    check("R2 mem_sel below", mem_sel, 0);
    drive_at_negedge();
    sel = 0; rd = 0;
  endtask

  task automatic t_first_powerup();
    drive_at_negedge();
    wp = 1;
    edges(2);
    check("R5 not yet armed edge2", armed, 0);
    edges(1);
    check("R5 armed edge3", armed, 1);
    edges(N - 1);
    check("R3 access off edge N+2", access_en, 0);
    edges(1);
    check("R3 access on edge N+3", access_en, 1);
  endtask

  task automatic t_access();
    drive_at_negedge();
    sel = 1; rd = 1; wr = 0;
    #1;
    check("R10 read drive", bus_drive, 1);
    check("R10 mem_sel", mem_sel, 1);
    check("R9 no strobe on read", mem_wr, 0);
    drive_at_negedge();
    rd = 0; wr = 1;
    #1;
    check("R9 write strobe", mem_wr, 1);
    check("R10 no drive on write", bus_drive, 0);
    drive_at_negedge();
    rd = 1; wr = 1;
    #1;
    check("R10 no drive rd+wr", bus_drive, 0);
    drive_at_negedge();
    sel = 0; rd = 0; wr = 0;
  endtask

  task automatic t_fail_wp_lower();
    drive_at_negedge();
    strap = 1;
    sel = 1; wr = 1;
    #1;
    check("R9 strobe before fail", mem_wr, 1);
    drive_at_negedge();
    wp = 0;
    edges(1);
    check("R1 still on edge1", access_en, 1);
    check("R7 no bkup edge1", bkup_sel, 0);
    edges(1);
    check("R1 access off edge2", access_en, 0);
    check("R9 write cancelled", mem_wr, 0);
    check("R2 mem_sel off", mem_sel, 0);
    check("R7 bkup on wp low", bkup_sel, 1);
    check("R5 stays armed", armed, 1);
    // restore with write still held
    drive_at_negedge();
    wp = 1;
    edges(N + 3);
    check("R3 access back", access_en, 1);
    check("R9 held write blocked", mem_wr, 0);
    check("R10 mem_sel back", mem_sel, 1);
    drive_at_negedge();
    wr = 0;
    drive_at_negedge();
    wr = 1;
    #1;
    check("R9 new write strobes", mem_wr, 1);
    drive_at_negedge();
    sel = 0; wr = 0;
  endtask

  task automatic t_fail_sw_lower();
    drive_at_negedge();
    strap = 0;
    wp = 0;
    edges(2);
    check("R8 wp low no bkup", bkup_sel, 0);
    check("R2 access off", access_en, 0);
    drive_at_negedge();
    sw = 0;
    edges(1);
    check("R8 edge1 no bkup", bkup_sel, 0);
    edges(1);
    check("R8 bkup on sw low", bkup_sel, 1);
    drive_at_negedge();
    sw = 1;
    edges(2);
    check("R8 bkup off sw high", bkup_sel, 0);
    drive_at_negedge();
    strap = 1;
    #1;
    check("R7 strap flips to wp", bkup_sel, 1);
  endtask

  task automatic t_dip();
    drive_at_negedge();
    wp = 1;
    edges(N / 2 + 2);
    check("R4 mid recovery off", access_en, 0);
    drive_at_negedge();
    wp = 0;
    edges(3);
    drive_at_negedge();
    wp = 1;
    edges(N + 2);
    check("R4 restart off edge N+2", access_en, 0);
    edges(1);
    check("R4 restart on edge N+3", access_en, 1);
    check("R7 bkup off when good", bkup_sel, 0);
  endtask

  task automatic t_rereset();
    drive_at_negedge();
    rst_n = 0;
    edges(1);
    check("R5 reset clears arm", armed, 0);
    drive_at_negedge();
    rst_n = 1;
    wp = 0; sw = 0;
    edges(4);
    check("R6 unarmed no bkup", bkup_sel, 0);
    power_up();
    check("R5 rearm", armed, 1);
    check("R3 access after powerup", access_en, 1);
  endtask

  initial begin
    t_reset();
    t_first_powerup();
    t_access();
    t_fail_wp_lower();
    t_fail_sw_lower();
    t_dip();
    t_rereset();
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule